// File: doc/BRIEF.md
# Looped Array Multiply-Add Controller

This block walks a short array of signed 32-bit words held in an external synchronous memory. For each word it writes one result to a second external memory: the word times a scalar `b`, plus the difference of two more scalars `c` and `d`. The three scalars come in on 8-bit ports and are sign-extended. The difference `c - d` does not change across the loop, so it is formed once in a setup cycle and held in a register. Each element then takes three cycles: issue the read, capture the returned word, then compute and write. With the default depth of three, a job takes ten cycles from start to the final write. A new job can begin straight after the final write cycle.

Software or a surrounding sequencer loads the input memory and holds `b`, `c` and `d` on the ports. It raises `start` for one cycle and waits for the one-cycle `done` pulse. The input memory must return data one cycle after a read request. The reset input is asynchronous and active low. Inside the block, reset is released in step with the clock.

Top module: `array_mac_loop`

## Requirements
- R1: If `start` is sampled high at rising edge E while the block is idle, `done` is high for exactly one cycle, between edges E+9 and E+10. `done` is low at every other time.
- R2: `in_ce` is high for one cycle each, with `in_addr` equal to 0, 1 and 2, between edges E+1/E+2, E+4/E+5 and E+7/E+8. It is low otherwise. `in_we` is always 0.
- R3: `out_ce` and `out_we` are high together for one cycle each, with `out_addr` equal to 0, 1 and 2, between edges E+3/E+4, E+6/E+7 and E+9/E+10. They are low otherwise. Each write goes to the address read two cycles earlier.
- R4: During a write, `out_wdata` equals the low 32 bits of `x*sext(b) + sext(c) - sext(d)`, in two's complement. Here `x` is the word the input memory returned in the cycle after the read at that address, and `b` is the value on the port during the write cycle.
- R5: `c` and `d` are sampled once, at edge E+1. Changes to them later in the job have no effect on that job's results.
- R6: `start` is ignored while a job is in progress. It causes no extra reads, writes or `done` pulses, and it does not change the job's timing.
- R7: If `start` is high at the edge that ends the final write cycle, the next job begins at once. Its sampling edge is that edge, which gives an initiation interval of 10 cycles.
- R8: While `rst_n` is low, `in_ce`, `out_ce`, `out_we` and `done` are low immediately, without waiting for a clock edge. After `rst_n` rises, the block is idle, and it accepts `start` once two rising edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a job when idle or in the final write cycle |
| b | input | 8 | Signed multiplier scalar, used live during writes |
| c | input | 8 | Signed addend scalar, sampled in the setup cycle |
| d | input | 8 | Signed subtrahend scalar, sampled in the setup cycle |
| in_addr | output | 2 | Input memory read address |
| in_ce | output | 1 | Input memory chip enable |
| in_we | output | 1 | Input memory write enable, held low |
| in_rdata | input | 32 | Input memory read data, one cycle after the request |
| out_addr | output | 2 | Output memory address |
| out_ce | output | 1 | Output memory chip enable |
| out_we | output | 1 | Output memory write enable |
| out_wdata | output | 32 | Output memory write data |
| done | output | 1 | One-cycle pulse in the last write cycle |

## Verification
The bench builds the block with its default parameters: 32-bit data, 8-bit scalars and a three-element array. With a loop that short, every cycle of every job can be compared against its expected strobe, address and data. A sweep crosses eight values of `b` with four pairs of `c` and `d`, including both 8-bit extremes, and element patterns that force the product to wrap. The sweep chains jobs back to back, changes `c` and `d` in the middle of a job and pulses `start` while the block is busy. A separate case applies reset in the middle of a job and then runs a clean job after it.

// File: rtl/array_mac_pkg.sv
package array_mac_pkg;

  // Sequencer states: idle, one setup cycle, then three per element
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ISSUE = 3'd2,
    ST_CAPT  = 3'd3,
    ST_WRITE = 3'd4
  } seq_state_e;

endpackage

// File: rtl/array_mac_rst_sync.sv
module array_mac_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic meta_q;
  logic hold_q;

  // Assert at once, release after two rising edges
  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;

endmodule

// File: rtl/array_mac_ctrl.sv
module array_mac_ctrl
  import array_mac_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             setup_en,
  output logic             capt_en,
  output logic             in_ce,
  output logic [IDX_W-1:0] in_addr,
  output logic             out_ce,
  output logic             out_we,
  output logic [IDX_W-1:0] out_addr,
  output logic             done
);

  localparam int unsigned     LAST     = DEPTH - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] iter_q, iter_d;
  logic [IDX_W-1:0] cur_q;
  logic             iter_en;
  logic             cur_en;
  logic             last_elem;

  assign last_elem = (cur_q == LAST_IDX);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_CAPT;
      ST_CAPT:  state_d = ST_WRITE;
      ST_WRITE: begin
        if (!last_elem)  state_d = ST_ISSUE;
        else if (start)  state_d = ST_SETUP;
        else             state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  // Iteration counter: cleared in setup, stepped on each read issue
  assign iter_en = (state_q == ST_SETUP) || (state_q == ST_ISSUE);
  assign cur_en  = (state_q == ST_ISSUE);

  always_comb begin
    if (state_q == ST_SETUP) iter_d = '0;
    else                     iter_d = iter_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q <= '0;
    end else if (iter_en) begin
      iter_q <= iter_d;
    end
  end

  // Index of the element now in flight, reused for the write address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (cur_en) begin
      cur_q <= iter_q;
    end
  end

  assign setup_en = (state_q == ST_SETUP);
  assign capt_en  = (state_q == ST_CAPT);
  assign in_ce    = (state_q == ST_ISSUE);
  assign in_addr  = iter_q;
  assign out_ce   = (state_q == ST_WRITE);
  assign out_we   = (state_q == ST_WRITE);
  assign out_addr = cur_q;
  assign done     = (state_q == ST_WRITE) && last_elem;

endmodule

// File: rtl/array_mac_datapath.sv
module array_mac_datapath #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_en,
  input  logic              capt_en,
  input  logic [SC_W-1:0]   b,
  input  logic [SC_W-1:0]   c,
  input  logic [SC_W-1:0]   d,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata
);

  localparam int unsigned EXT_W = DATA_W - SC_W;

  logic signed [DATA_W-1:0] b_ext, c_ext, d_ext;
  logic signed [DATA_W-1:0] bias_d, bias_q;
  logic signed [DATA_W-1:0] opnd_q;
  logic signed [DATA_W-1:0] prod_lo;

  assign b_ext = {{EXT_W{b[SC_W-1]}}, b};
  assign c_ext = {{EXT_W{c[SC_W-1]}}, c};
  assign d_ext = {{EXT_W{d[SC_W-1]}}, d};

  // Loop-invariant term, formed once per job
  assign bias_d = c_ext - d_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_q <= '0;
    end else if (setup_en) begin
      bias_q <= bias_d;
    end
  end

  // Operand register loaded from the memory read bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
    end else if (capt_en) begin
      opnd_q <= rdata;
    end
  end

  // Low half of the signed product, then add the invariant term
  assign prod_lo = opnd_q * b_ext;
  assign wdata   = prod_lo + bias_q;

endmodule

// File: rtl/array_mac_loop.sv
module array_mac_loop #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SC_W   = 8,
  parameter int unsigned DEPTH  = 3,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SC_W-1:0]   b,
  input  logic [SC_W-1:0]   c,
  input  logic [SC_W-1:0]   d,
  output logic [IDX_W-1:0]  in_addr,
  output logic              in_ce,
  output logic              in_we,
  input  logic [DATA_W-1:0] in_rdata,
  output logic [IDX_W-1:0]  out_addr,
  output logic              out_ce,
  output logic              out_we,
  output logic [DATA_W-1:0] out_wdata,
  output logic              done
);

  logic rst_sync_n;
  logic setup_en;
  logic capt_en;

  array_mac_rst_sync rst_sync_i (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  array_mac_ctrl #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .setup_en (setup_en),
    .capt_en  (capt_en),
    .in_ce    (in_ce),
    .in_addr  (in_addr),
    .out_ce   (out_ce),
    .out_we   (out_we),
    .out_addr (out_addr),
    .done     (done)
  );

  array_mac_datapath #(
    .DATA_W (DATA_W),
    .SC_W   (SC_W)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .setup_en (setup_en),
    .capt_en  (capt_en),
    .b        (b),
    .c        (c),
    .d        (d),
    .rdata    (in_rdata),
    .wdata    (out_wdata)
  );

  // The input array is read only
  assign in_we = 1'b0;

endmodule

// File: rtl/array_mac_loop_chk.sv
module array_mac_loop_chk #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ce,
  input logic [IDX_W-1:0] in_addr,
  input logic             out_ce,
  input logic             out_we,
  input logic [IDX_W-1:0] out_addr,
  input logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_ce && out_we && out_addr == LAST_IDX));

  // R2
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ce |=> (!in_ce && !out_ce));

  // R3
  write_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ce |=> ##1 (out_ce && out_we));

  // R3
  write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ce ##2 out_ce) |-> (out_addr == $past(in_addr, 2)));

  // R3
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ce && out_ce));

endmodule

bind array_mac_loop array_mac_loop_chk #(
  .DEPTH (DEPTH),
  .IDX_W (IDX_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_ce    (in_ce),
  .in_addr  (in_addr),
  .out_ce   (out_ce),
  .out_we   (out_we),
  .out_addr (out_addr),
  .done     (done)
);

// File: tb/array_mac_loop_tb_top.sv
`timescale 1ns/1ps
module array_mac_loop_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [7:0]  b, c, d;
  logic [1:0]  in_addr, out_addr;
  logic        in_ce, in_we, out_ce, out_we, done;
  logic [31:0] in_rdata, out_wdata;

  logic [31:0] in_mem [0:3];
  int          n_chk;
  int          n_fail;
  bit          finished;

  array_mac_loop dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .b         (b),
    .c         (c),
    .d         (d),
    .in_addr   (in_addr),
    .in_ce     (in_ce),
    .in_we     (in_we),
    .in_rdata  (in_rdata),
    .out_addr  (out_addr),
    .out_ce    (out_ce),
    .out_we    (out_we),
    .out_wdata (out_wdata),
    .done      (done)
  );

  // 50 MHz clock
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Input memory model, one-cycle read latency
  always @(posedge clk) begin
    if (in_ce) in_rdata <= in_mem[in_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_y(input logic [31:0] x, input logic [7:0] jb,
                                           input logic [7:0] jc, input logic [7:0] jd);
    logic signed [31:0] bx, cx, dx;
    bx = 32'(signed'(jb));
    cx = 32'(signed'(jc));
    dx = 32'(signed'(jd));
    return (x * bx) + (cx - dx);
  endfunction

  // Enters and leaves at a falling edge; start sampled at the next rising edge
  task automatic run_job(input logic [7:0] jb, input logic [7:0] jc, input logic [7:0] jd,
                         input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2,
                         input bit disturb_cd, input bit busy_start);
    logic [31:0] elems [0:2];
    elems[0] = e0; elems[1] = e1; elems[2] = e2;
    in_mem[0] = e0; in_mem[1] = e1; in_mem[2] = e2;
    b = jb; c = jc; d = jd;
    start = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      // R5: scalars change after sampling edge
      if (disturb_cd && k == 2) begin c = ~jc; d = jc; end
      // R6: start pulsed while busy
      if (busy_start && k == 5) start = 1'b1;
      if (busy_start && k == 6) start = 1'b0;
      if (k == 2 || k == 5 || k == 8) begin
        chk(in_ce && in_addr == 2'((k - 2) / 3), "R2", "read strobe/addr",
            {in_ce, in_addr}, {1'b1, 2'((k - 2) / 3)});
      end else begin
        chk(!in_ce, "R2", "read idle", in_ce, 0);
      end
      chk(!in_we, "R2", "in_we", in_we, 0);
      if (k == 4 || k == 7 || k == 10) begin
        chk(out_ce && out_we && out_addr == 2'((k - 4) / 3), "R3", "write strobe/addr",
            {out_ce, out_we, out_addr}, {2'b11, 2'((k - 4) / 3)});
        chk(out_wdata == expect_y(elems[(k - 4) / 3], jb, jc, jd), "R4", "write data",
            out_wdata, expect_y(elems[(k - 4) / 3], jb, jc, jd));
      end else begin
        chk(!out_ce && !out_we, "R3", "write idle", {out_ce, out_we}, 0);
      end
      chk(done == (k == 10), "R1", "done timing", done, (k == 10));
    end
  endtask

  task automatic check_quiet(input int cycles, input string req);
    for (int q = 0; q < cycles; q++) begin
      @(negedge clk);
      chk(!in_ce && !out_ce && !out_we && !done, req, "quiet after job",
          {in_ce, out_ce, out_we, done}, 0);
    end
  endtask

  function automatic logic [7:0] pick_b(input int i);
    case (i)
      0: return 8'h80;   // -128
      1: return 8'hFF;   // -1
      2: return 8'h00;
      3: return 8'h01;
      4: return 8'h02;
      5: return 8'h7F;   // 127
      6: return 8'h25;
      default: return 8'hB3;
    endcase
  endfunction

  function automatic logic [7:0] pick_c(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h7F;
      2: return 8'h80;
      default: return 8'hFB;
    endcase
  endfunction

  function automatic logic [7:0] pick_d(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h80;
      2: return 8'h7F;
      default: return 8'h09;
    endcase
  endfunction

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; b = '0; c = '0; d = '0;
    for (int i = 0; i < 4; i++) in_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!in_ce && !out_ce && !out_we && !done, "R8", "reset outputs",
        {in_ce, out_ce, out_we, done}, 0);
    rst_n = 1'b1;
    check_quiet(4, "R8");

    // Directed wrap case: R4 truncation
    run_job(8'h80, 8'h7F, 8'h80, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0);
    check_quiet(2, "R1");

    // Sweep: chained inside each b (R7), disturbed scalars (R5), busy start (R6)
    for (int bi = 0; bi < 8; bi++) begin
      for (int ci = 0; ci < 4; ci++) begin
        int s;
        s = bi * 4 + ci;
        run_job(pick_b(bi), pick_c(ci), pick_d(ci),
                32'(s * 32'h01F3_5A7B) ^ ((s % 2 == 1) ? 32'h8000_0000 : 32'h0),
                32'(s) - 32'd17,
                32'h7FFF_0000 + 32'(s * 977),
                (ci == 1), (ci == 2));
      end
      check_quiet(3, "R6");
    end

    // R8: reset in the middle of a job
    in_mem[0] = 32'd5; in_mem[1] = 32'd6; in_mem[2] = 32'd7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!in_ce && !out_ce && !out_we && !done, "R8", "async clear",
        {in_ce, out_ce, out_we, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    check_quiet(4, "R8");
    run_job(8'h03, 8'h04, 8'h01, 32'd10, 32'hFFFF_FFF6, 32'd0, 0, 0);
    check_quiet(2, "R8");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule